// File: doc/BRIEF.md
# JK-Entry Universal Shift Register

This block is a synchronous right-shifting register of parameterized width, four bits by default. Each rising clock edge does one of two things. It either captures a whole parallel word, or it moves every stored bit one place toward the higher index. In the second case, the lowest stage takes a new value from a pair of serial inputs with JK behaviour. With that pair, the first stage can toggle, hold, or behave as a plain D input when both lines carry the same level.

Every stored bit is visible on a parallel output. An output polarity select shows either the stored bits or their inverses, without touching the stored value. An active-high asynchronous clear empties the register immediately and overrides every other operation.

Top module: `usr_jk_shreg`

## Requirements
- R1: The stored value changes only on a rising edge of `clk` (apart from reset); input changes between edges leave `q_out` unchanged.
- R2: With `load_en` = 1, a rising edge stores `par_in` into every stage; bit i of `par_in` goes to stage i; `j_in`/`k_in` have no effect.
- R3: With `load_en` = 0, a rising edge moves stage i-1 into stage i for every i ≥ 1; the old value of the highest stage is discarded.
- R4: During a shift with `j_in` = 1 and `k_in` = 0, stage 0 takes the inverse of its previous value.
- R5: During a shift with `j_in` = 0 and `k_in` = 1, stage 0 keeps its previous value.
- R6: During a shift with `j_in` = `k_in`, stage 0 takes that shared level.
- R7: While `rst` = 1, all stages are cleared to 0 at once, without waiting for a clock edge, and a clock edge does not load or shift.
- R8: With `true_sel` = 1, `q_out[i]` equals stage i.
- R9: With `true_sel` = 0, `q_out[i]` is the inverse of stage i; changing `true_sel` does not alter the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous clear, active high |
| load_en | input | 1 | 1 = parallel load, 0 = right shift |
| par_in | input | WIDTH | Parallel data word |
| j_in | input | 1 | Serial J input for stage 0 |
| k_in | input | 1 | Serial K input for stage 0 (active-low sense) |
| true_sel | input | 1 | 1 = true outputs, 0 = complemented outputs |
| q_out | output | WIDTH | Parallel outputs, one per stage |

## Verification
The bench builds two copies. The first uses the default width of 4. Its short chain lets a vector table cover loads, every JK entry mode and both polarities within a handful of edges. The second uses a width of 7, so a bit loaded at the top stage can be seen to drop off the end while a bit at stage 0 travels up. This shows that nothing in the shift path is tied to a width of four.

// File: rtl/usr_pkg.sv
package usr_pkg;
    typedef enum logic {
        OP_SHIFT = 1'b0,
        OP_LOAD  = 1'b1
    } usr_op_t;
endpackage

// File: rtl/usr_jk_entry.sv
module usr_jk_entry (
    input  logic cur_bit,
    input  logic j_bit,
    input  logic k_bit,
    output logic nxt_bit
);
    // K is active low: K=1 keeps a 1, J=1 sets from 0
    always_comb begin
        nxt_bit = (j_bit & ~cur_bit) | (k_bit & cur_bit);
    end
endmodule

// File: rtl/usr_pol_sel.sv
module usr_pol_sel #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] stored,
    input  logic             true_sel,
    output logic [WIDTH-1:0] shown
);
    localparam int LAST = WIDTH - 1;

    for (genvar i = 0; i <= LAST; i++) begin : g_bit
        assign shown[i] = true_sel ? stored[i] : ~stored[i];
    end
endmodule

// File: rtl/usr_jk_shreg.sv
module usr_jk_shreg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] par_in,
    input  logic             j_in,
    input  logic             k_in,
    input  logic             true_sel,
    output logic [WIDTH-1:0] q_out
);
    import usr_pkg::*;

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } state_t;

    state_t     state_d;
    state_t     state_q;
    usr_op_t    op;
    logic [WIDTH-1:0] stored;
    logic       entry_bit;

    assign stored = state_q.bits;

    usr_jk_entry u_entry (
        .cur_bit (stored[0]),
        .j_bit   (j_in),
        .k_bit   (k_in),
        .nxt_bit (entry_bit)
    );

    always_comb begin
        op      = load_en ? OP_LOAD : OP_SHIFT;
        state_d = state_q;
        case (op)
            OP_LOAD: state_d.bits = par_in;
            default: begin
                for (int i = TOP; i >= 1; i--) begin
                    state_d.bits[i] = state_q.bits[i-1];
                end
                state_d.bits[0] = entry_bit;
            end
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    usr_pol_sel #(.WIDTH(WIDTH)) u_pol (
        .stored   (stored),
        .true_sel (true_sel),
        .shown    (q_out)
    );
endmodule

// File: rtl/usr_jk_shreg_chk.sv
module usr_jk_shreg_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             load_en,
    input logic [WIDTH-1:0] par_in,
    input logic             j_in,
    input logic             k_in,
    input logic             true_sel,
    input logic [WIDTH-1:0] q_out,
    input logic [WIDTH-1:0] bits_q
);
    // R2
    load_word_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> bits_q == $past(par_in));

    // R3
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> bits_q[WIDTH-1:1] == $past(bits_q[WIDTH-2:0]));

    // R4
    entry_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && j_in && !k_in) |=> bits_q[0] != $past(bits_q[0]));

    // R5
    entry_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !j_in && k_in) |=> $stable(bits_q[0]));

    // R6
    entry_d_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && (j_in == k_in)) |=> bits_q[0] == $past(j_in));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |-> bits_q == '0);

    // R8
    true_view_chk: assert property (@(posedge clk) disable iff (rst)
        true_sel |-> q_out == bits_q);

    // R9
    inv_view_chk: assert property (@(posedge clk) disable iff (rst)
        !true_sel |-> q_out == ~bits_q);
endmodule

bind usr_jk_shreg usr_jk_shreg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .par_in   (par_in),
    .j_in     (j_in),
    .k_in     (k_in),
    .true_sel (true_sel),
    .q_out    (q_out),
    .bits_q   (stored)
);

// File: tb/usr_jk_shreg_test.sv
`timescale 1ns/1ps
module usr_jk_shreg_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst;
    logic       load_en, j_in, k_in, true_sel;
    logic [3:0] par_in;
    logic [3:0] q_out;

    logic       w_load, w_j, w_k, w_tsel;
    logic [6:0] w_par;
    logic [6:0] w_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    usr_jk_shreg #(.WIDTH(4)) uut (
        .clk(clk), .rst(rst), .load_en(load_en), .par_in(par_in),
        .j_in(j_in), .k_in(k_in), .true_sel(true_sel), .q_out(q_out)
    );

    usr_jk_shreg #(.WIDTH(7)) uut_w7 (
        .clk(clk), .rst(rst), .load_en(w_load), .par_in(w_par),
        .j_in(w_j), .k_in(w_k), .true_sel(w_tsel), .q_out(w_q)
    );

    // {load, par[3:0], j, k, tsel, expected q[3:0]}
    localparam int NV = 13;
    localparam logic [11:0] VEC [NV] = '{
        {1'b1, 4'b1010, 1'b0, 1'b0, 1'b1, 4'b1010}, // R2 load
        {1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 4'b0101}, // R3 R6 D=1
        {1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b1010}, // R6 D=0
        {1'b0, 4'b0000, 1'b1, 1'b0, 1'b1, 4'b0101}, // R4 toggle 0->1
        {1'b0, 4'b0000, 1'b1, 1'b0, 1'b1, 4'b1010}, // R4 toggle 1->0
        {1'b0, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b0100}, // R5 hold 0
        {1'b0, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b1000}, // R5 hold 0
        {1'b1, 4'b0110, 1'b0, 1'b0, 1'b0, 4'b1001}, // R2 R9 load, inverted view
        {1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0010}, // R6 R9
        {1'b0, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b1011}, // R5 hold 1, R8
        {1'b0, 4'b0000, 1'b1, 1'b0, 1'b1, 4'b0110}, // R4 toggle 1->0
        {1'b1, 4'b1111, 1'b1, 1'b0, 1'b1, 4'b1111}, // R2 load ignores J/K
        {1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b1110}  // R3 top bit discarded
    };

    task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: q_out=%b expected %b", req, act, exp);
        end
    endtask

    task automatic check7(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: q_out=%b expected %b", req, act, exp);
        end
    endtask

    initial begin
        #1600000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; load_en = 1'b0; par_in = '0; j_in = 1'b0; k_in = 1'b0; true_sel = 1'b1;
        w_load = 1'b0; w_par = '0; w_j = 1'b0; w_k = 1'b0; w_tsel = 1'b1;
        repeat (3) @(negedge clk);
        check4("R7 reset state", q_out, 4'b0000);
        true_sel = 1'b0;
        #1;
        check4("R9 reset state inverted", q_out, 4'b1111);
        true_sel = 1'b1;
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {load_en, par_in, j_in, k_in, true_sel} = VEC[v][11:4];
            @(posedge clk);
            #1;
            check4($sformatf("R2-R9 vector %0d", v), q_out, VEC[v][3:0]);
        end

        // R1: inputs change away from an edge, output unchanged
        @(negedge clk);
        load_en = 1'b1; par_in = 4'b0101; true_sel = 1'b1;
        #1;
        check4("R1 no change before edge", q_out, 4'b1110);
        @(posedge clk); #1;
        check4("R1 change at edge", q_out, 4'b0101);

        // R9: polarity flip leaves state intact
        @(negedge clk);
        load_en = 1'b0; j_in = 1'b0; k_in = 1'b1; true_sel = 1'b0;
        #1;
        check4("R9 inverted view", q_out, 4'b1010);
        true_sel = 1'b1;
        #1;
        check4("R9 state kept after flip", q_out, 4'b0101);

        // R7: asynchronous clear, mid-cycle, with load requested
        @(negedge clk);
        load_en = 1'b1; par_in = 4'b1111;
        @(posedge clk); #1;
        check4("R2 load before clear", q_out, 4'b1111);
        #1;
        rst = 1'b1;
        #1;
        check4("R7 clear without edge", q_out, 4'b0000);
        @(posedge clk); #1;
        check4("R7 clear overrides load", q_out, 4'b0000);
        @(negedge clk);
        rst = 1'b0;

        // R3 on width 7: top bit drops off, bottom bit moves up
        w_load = 1'b1; w_par = 7'b1000001;
        @(posedge clk); #1;
        check7("R2 wide load", w_q, 7'b1000001);
        @(negedge clk);
        w_load = 1'b0; w_j = 1'b0; w_k = 1'b0;
        @(posedge clk); #1;
        check7("R3 wide discard", w_q, 7'b0000010);
        @(negedge clk);
        w_j = 1'b1; w_k = 1'b0;
        @(posedge clk); #1;
        check7("R4 wide toggle", w_q, 7'b0000101);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule